// File: doc/BRIEF.md
# Privileged Control Register Access Unit

This unit holds a processor's four control registers (indices 0, 2, 3 and 4), a bank of debug registers, and a set of test registers that have no storage. It serves one move request per cycle. Each request is a read or a write and carries a register class, an index and a 32-bit word. Before the unit touches any state, it checks the request against the current privilege level, the virtual-8086 flag and the protection-enable bit of control register 0.

A write to a control register can have side effects, and the unit reports them as one-cycle strobes: a TLB flush, a wait-state update, and a change of the protected-mode and internal-cache-enable levels. A few configuration inputs select processor-family behaviour. These are the 486-class read-back of the extension-type bit, a 16-bit bus, whether register 4 exists, and whether an internal cache is present. Each response carries read data, one fault flag per fault kind, and the number of clock cycles the instruction costs.

Top module: `ctl_reg_unit`

## Requirements
- R1: When CR0 bit 0 is 1 and either `priv_level` is nonzero or `vm_flag` is 1, every request raises `fault_gp` and returns read data 0, cycle count 0 and no strobes. No register changes. When CR0 bit 0 is 0, neither condition causes a fault.
- R2: Register class encoding: 0 = control, 1 = debug, 2 = test, 3 = reserved. A control index other than 0, 2, 3 or 4 raises `fault_ud`. Index 4 raises it when `cfg_has_cr4` is 0. Class 3 always raises it. The two fault outputs are never both 1.
- R3: A read of CR0 returns bit 4 as 1 while `cfg_is486` is 1. Otherwise it returns the stored value.
- R4: A CR0 write pulses `tlb_flush` when bit 31 or bit 0 of the written word differs from the stored CR0.
- R5: A CR0 write stores the word with bit 4 set to 1 while `cfg_bus16` is 1.
- R6: `pmode` equals stored CR0 bit 0. After a CR0 write it equals bit 0 of the written word.
- R7: `cache_int_en` is `cfg_has_cache` AND NOT CR0 bit 30. A CR0 write that changes bit 30 pulses `wait_update` only when `cfg_has_cache` is 1.
- R8: Every CR3 write pulses `tlb_flush`, whatever the data. A CR2 write does not.
- R9: A CR4 write stores the word ANDed with parameter `CR4_MASK`. It pulses `tlb_flush` when masked bit 5 changes.
- R10: A test register read returns 0. A test register write changes no register and raises no strobe.
- R11: `rsp_cycles` is 10 for a control-class write, 6 for every other request without a general-protection fault, and 0 on a general-protection fault.
- R12: `rsp_done` and all results appear in the cycle after `req_valid` is sampled and last one cycle. `tlb_flush` and `wait_update` are 1 only together with `rsp_done`.
- R13: After reset, all control and debug registers read 0, except CR0 bit 4, which takes the value of `cfg_bus16`.
- R14: A debug register read returns the last word written to the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_has_cr4 | input | 1 | Control register 4 exists |
| cfg_is486 | input | 1 | Read-back of CR0 bit 4 forced to 1 |
| cfg_bus16 | input | 1 | 16-bit bus: CR0 bit 4 stored as 1 |
| cfg_has_cache | input | 1 | Internal cache present |
| priv_level | input | 2 | Current privilege level |
| vm_flag | input | 1 | Virtual-8086 mode flag |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move to register, 0 = move from register |
| req_class | input | 2 | Register class (see R2) |
| req_index | input | 3 | Register index |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | Response valid |
| rsp_rdata | output | 32 | Read data |
| fault_gp | output | 1 | General-protection fault |
| fault_ud | output | 1 | Invalid-opcode fault |
| rsp_cycles | output | 4 | Instruction cycle count |
| tlb_flush | output | 1 | TLB flush strobe |
| wait_update | output | 1 | Wait-state update strobe |
| pmode | output | 1 | Protected-mode status |
| cache_int_en | output | 1 | Internal cache enable |

## Verification
The state is held in registers, so a corrupted register stays hidden until it is read back. The one exception is CR0: its bits 0 and 30 drive `pmode` and `cache_int_en` directly, so a wrong CR0 value shows at those ports in the cycle after the write. A wrong control or debug value appears only at the next read of that index, one cycle after that read is issued. A wrong stored value in bits 31, 0 or masked bit 5 also shows earlier, as a missing or extra flush strobe on the next write. For that reason the bench follows every write with a read of the same register, and it records the strobe pattern of each write.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    typedef enum logic [1:0] {
        CLS_CTRL = 2'd0,
        CLS_DBG  = 2'd1,
        CLS_TEST = 2'd2,
        CLS_RSVD = 2'd3
    } reg_class_e;

    // Bit positions inside the control words
    localparam int unsigned CR0_PE_BIT  = 0;
    localparam int unsigned CR0_ET_BIT  = 4;
    localparam int unsigned CR0_CD_BIT  = 30;
    localparam int unsigned CR0_PG_BIT  = 31;
    localparam int unsigned CR4_PAE_BIT = 5;
endpackage

// File: rtl/ctl_access_check.sv
module ctl_access_check
    import ctl_pkg::*;
#(
    parameter int unsigned IDX_W = 3
) (
    input  logic [1:0]       priv_level,
    input  logic             vm_flag,
    input  logic             pe_bit,
    input  reg_class_e       cls,
    input  logic [IDX_W-1:0] idx,
    input  logic             has_cr4,
    output logic             gp,
    output logic             ud
);
    logic ctrl_ok;

    always_comb begin
        gp = pe_bit && ((priv_level != 2'd0) || vm_flag);
        case (idx)
            IDX_W'(0), IDX_W'(2), IDX_W'(3): ctrl_ok = 1'b1;
            IDX_W'(4):                       ctrl_ok = has_cr4;
            default:                         ctrl_ok = 1'b0;
        endcase
        case (cls)
            CLS_CTRL: ud = !gp && !ctrl_ok;
            CLS_RSVD: ud = !gp;
            default:  ud = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctl_cr0_effects.sv
module ctl_cr0_effects
    import ctl_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] wdata,
    input  logic          bus16,
    input  logic          has_cache,
    output logic [DW-1:0] next,
    output logic          flush,
    output logic          wait_upd
);
    logic [DW-1:0] diff;

    always_comb begin
        diff     = wdata ^ cur;
        next     = wdata;
        next[CR0_ET_BIT] = wdata[CR0_ET_BIT] | bus16;
        flush    = diff[CR0_PG_BIT] | diff[CR0_PE_BIT];
        wait_upd = has_cache & (next[CR0_CD_BIT] ^ cur[CR0_CD_BIT]);
    end
endmodule

// File: rtl/ctl_cr4_effects.sv
module ctl_cr4_effects
    import ctl_pkg::*;
#(
    parameter int unsigned     DW   = 32,
    parameter logic [DW-1:0]   MASK = '1
) (
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] next,
    output logic          flush
);
    logic [DW-1:0] change;

    always_comb begin
        next   = wdata & MASK;
        change = (wdata ^ cur) & MASK;
        flush  = change[CR4_PAE_BIT];
    end
endmodule

// File: rtl/ctl_reg_unit.sv
module ctl_reg_unit
    import ctl_pkg::*;
#(
    parameter int unsigned        IDX_W      = 3,
    parameter int unsigned        CYC_W      = 4,
    parameter int unsigned        CYC_SHORT  = 6,
    parameter int unsigned        CYC_LONG   = 10,
    parameter logic [31:0]        CR4_MASK   = 32'h0000_0A7F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_has_cr4,
    input  logic             cfg_is486,
    input  logic             cfg_bus16,
    input  logic             cfg_has_cache,
    input  logic [1:0]       priv_level,
    input  logic             vm_flag,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_class,
    input  logic [IDX_W-1:0] req_index,
    input  logic [31:0]      req_wdata,
    output logic             rsp_done,
    output logic [31:0]      rsp_rdata,
    output logic             fault_gp,
    output logic             fault_ud,
    output logic [CYC_W-1:0] rsp_cycles,
    output logic             tlb_flush,
    output logic             wait_update,
    output logic             pmode,
    output logic             cache_int_en
);
    localparam int unsigned DW      = 32;
    localparam int unsigned NUM_DBG = 1 << IDX_W;

    typedef struct packed {
        logic [DW-1:0]              cr0;
        logic [DW-1:0]              cr2;
        logic [DW-1:0]              cr3;
        logic [DW-1:0]              cr4;
        logic [NUM_DBG-1:0][DW-1:0] dbg;
        logic                       done;
        logic                       gp;
        logic                       ud;
        logic                       flush;
        logic                       waitu;
        logic [DW-1:0]              rdata;
        logic [CYC_W-1:0]           cycles;
    } state_t;

    state_t     s_d, s_q;
    reg_class_e cls;
    logic       chk_gp, chk_ud;
    logic [DW-1:0] cr0_new, cr4_new;
    logic       cr0_flush, cr0_wait, cr4_flush;

    assign cls = reg_class_e'(req_class);

    ctl_access_check #(.IDX_W(IDX_W)) u_check (
        .priv_level (priv_level),
        .vm_flag    (vm_flag),
        .pe_bit     (s_q.cr0[CR0_PE_BIT]),
        .cls        (cls),
        .idx        (req_index),
        .has_cr4    (cfg_has_cr4),
        .gp         (chk_gp),
        .ud         (chk_ud)
    );

    ctl_cr0_effects #(.DW(DW)) u_cr0 (
        .cur       (s_q.cr0),
        .wdata     (req_wdata),
        .bus16     (cfg_bus16),
        .has_cache (cfg_has_cache),
        .next      (cr0_new),
        .flush     (cr0_flush),
        .wait_upd  (cr0_wait)
    );

    ctl_cr4_effects #(.DW(DW), .MASK(CR4_MASK)) u_cr4 (
        .cur   (s_q.cr4),
        .wdata (req_wdata),
        .next  (cr4_new),
        .flush (cr4_flush)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.gp     = 1'b0;
        s_d.ud     = 1'b0;
        s_d.flush  = 1'b0;
        s_d.waitu  = 1'b0;
        s_d.rdata  = '0;
        s_d.cycles = '0;
        if (req_valid) begin
            s_d.done = 1'b1;
            if (chk_gp) begin
                s_d.gp = 1'b1;
            end else begin
                s_d.cycles = (req_write && cls == CLS_CTRL) ? CYC_W'(CYC_LONG)
                                                            : CYC_W'(CYC_SHORT);
                if (chk_ud) begin
                    s_d.ud = 1'b1;
                end else if (req_write) begin
                    case (cls)
                        CLS_CTRL: begin
                            case (req_index)
                                IDX_W'(0): begin
                                    s_d.cr0   = cr0_new;
                                    s_d.flush = cr0_flush;
                                    s_d.waitu = cr0_wait;
                                end
                                IDX_W'(2): s_d.cr2 = req_wdata;
                                IDX_W'(3): begin
                                    s_d.cr3   = req_wdata;
                                    s_d.flush = 1'b1;
                                end
                                default: begin
                                    s_d.cr4   = cr4_new;
                                    s_d.flush = cr4_flush;
                                end
                            endcase
                        end
                        CLS_DBG: s_d.dbg[req_index] = req_wdata;
                        default: ;
                    endcase
                end else begin
                    case (cls)
                        CLS_CTRL: begin
                            case (req_index)
                                IDX_W'(0): begin
                                    s_d.rdata = s_q.cr0;
                                    s_d.rdata[CR0_ET_BIT] = s_q.cr0[CR0_ET_BIT] | cfg_is486;
                                end
                                IDX_W'(2): s_d.rdata = s_q.cr2;
                                IDX_W'(3): s_d.rdata = s_q.cr3;
                                default:   s_d.rdata = s_q.cr4;
                            endcase
                        end
                        CLS_DBG: s_d.rdata = s_q.dbg[req_index];
                        default: s_d.rdata = '0;
                    endcase
                end
            end
        end
        if (!rst_n) begin
            s_d = '0;
            s_d.cr0[CR0_ET_BIT] = cfg_bus16;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign rsp_done     = s_q.done;
    assign rsp_rdata    = s_q.rdata;
    assign fault_gp     = s_q.gp;
    assign fault_ud     = s_q.ud;
    assign rsp_cycles   = s_q.cycles;
    assign tlb_flush    = s_q.flush;
    assign wait_update  = s_q.waitu;
    assign pmode        = s_q.cr0[CR0_PE_BIT];
    assign cache_int_en = cfg_has_cache & ~s_q.cr0[CR0_CD_BIT];

    // R1: a faulting request leaves the registers alone and costs nothing
    a_r1_gp_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_gp) |=> (fault_gp && rsp_cycles == '0 && !tlb_flush
                                   && $stable(s_q.cr0) && $stable(s_q.cr3)));

    // R2: never both fault kinds at once
    a_r2_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_gp && fault_ud));

    // R6: protected-mode level follows the written bit 0
    a_r6_pmode_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && cls == CLS_CTRL && req_index == '0 && !chk_gp)
        |=> (pmode == $past(req_wdata[0])));

    // R8: a CR3 write always flushes
    a_r8_cr3_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && cls == CLS_CTRL && req_index == IDX_W'(3) && !chk_gp)
        |=> tlb_flush);

    // R11: the cycle count takes only the legal values
    a_r11_cycles_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !fault_gp) |-> (rsp_cycles == CYC_W'(CYC_SHORT)
                                     || rsp_cycles == CYC_W'(CYC_LONG)));

    // R12: strobes only appear inside a response
    a_r12_strobe_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_flush || wait_update) |-> rsp_done);
endmodule

// File: tb/ctl_reg_unit_tb.sv
`timescale 1ns/1ps
module ctl_reg_unit_tb;
    localparam logic [31:0] TB_MASK = 32'h0000_0A7F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_has_cr4 = 1'b1, cfg_is486 = 1'b0, cfg_bus16 = 1'b1, cfg_has_cache = 1'b1;
    logic [1:0]  priv_level = 2'd0;
    logic        vm_flag = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_class = 2'd0;
    logic [2:0]  req_index = 3'd0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done, fault_gp, fault_ud, tlb_flush, wait_update, pmode, cache_int_en;
    logic [31:0] rsp_rdata;
    logic [3:0]  rsp_cycles;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    ctl_reg_unit #(.CR4_MASK(TB_MASK)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_has_cr4(cfg_has_cr4), .cfg_is486(cfg_is486), .cfg_bus16(cfg_bus16),
        .cfg_has_cache(cfg_has_cache), .priv_level(priv_level), .vm_flag(vm_flag),
        .req_valid(req_valid), .req_write(req_write), .req_class(req_class),
        .req_index(req_index), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .fault_gp(fault_gp),
        .fault_ud(fault_ud), .rsp_cycles(rsp_cycles), .tlb_flush(tlb_flush),
        .wait_update(wait_update), .pmode(pmode), .cache_int_en(cache_int_en)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  cls;
        logic [2:0]  idx;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic        ud;
        logic        flush;
        logic        waitu;
        logic [3:0]  cyc;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 2'd0, 3'd0, 32'h0,           32'h0000_0010, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 2'd0, 3'd0, 32'h8000_0001,   32'h0,         1'b0, 1'b1, 1'b0, 4'd10},
        '{1'b0, 2'd0, 3'd0, 32'h0,           32'h8000_0011, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 2'd0, 3'd0, 32'hC000_0001,   32'h0,         1'b0, 1'b0, 1'b1, 4'd10},
        '{1'b0, 2'd0, 3'd0, 32'h0,           32'hC000_0011, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 2'd0, 3'd2, 32'h1234_5678,   32'h0,         1'b0, 1'b0, 1'b0, 4'd10},
        '{1'b0, 2'd0, 3'd2, 32'h0,           32'h1234_5678, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 2'd0, 3'd3, 32'h0000_1000,   32'h0,         1'b0, 1'b1, 1'b0, 4'd10},
        '{1'b1, 2'd0, 3'd3, 32'h0000_1000,   32'h0,         1'b0, 1'b1, 1'b0, 4'd10},
        '{1'b0, 2'd0, 3'd3, 32'h0,           32'h0000_1000, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 2'd0, 3'd4, 32'hFFFF_FFFF,   32'h0,         1'b0, 1'b1, 1'b0, 4'd10},
        '{1'b0, 2'd0, 3'd4, 32'h0,           32'h0000_0A7F, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 2'd0, 3'd4, 32'hFFFF_FFDF,   32'h0,         1'b0, 1'b1, 1'b0, 4'd10},
        '{1'b1, 2'd0, 3'd4, 32'h0000_0000,   32'h0,         1'b0, 1'b0, 1'b0, 4'd10},
        '{1'b1, 2'd1, 3'd3, 32'hDEAD_BEEF,   32'h0,         1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, 2'd1, 3'd3, 32'h0,           32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, 2'd1, 3'd7, 32'h0,           32'h0,         1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 2'd2, 3'd6, 32'hFFFF_FFFF,   32'h0,         1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, 2'd2, 3'd6, 32'h0,           32'h0,         1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, 2'd1, 3'd3, 32'h0,           32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b0, 2'd0, 3'd1, 32'h0,           32'h0,         1'b1, 1'b0, 1'b0, 4'd6},
        '{1'b1, 2'd0, 3'd5, 32'h0000_FFFF,   32'h0,         1'b1, 1'b0, 1'b0, 4'd10},
        '{1'b0, 2'd3, 3'd0, 32'h0,           32'h0,         1'b1, 1'b0, 1'b0, 4'd6}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue one request; outputs are sampled at the following falling edge
    task automatic req(input logic wr, input logic [1:0] cls, input logic [2:0] idx,
                       input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_class = cls; req_index = idx; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset state
        chk("R13 done idle", {31'd0, rsp_done}, 32'd0);
        chk("R13 pmode", {31'd0, pmode}, 32'd0);
        chk("R7 cache_int_en after reset", {31'd0, cache_int_en}, 32'd1);
        req(1'b0, 2'd0, 3'd0, 32'h0);
        chk("R13 CR0 bit4 from bus16", rsp_rdata, 32'h0000_0010);
        chk("R12 done", {31'd0, rsp_done}, 32'd1);
        @(negedge clk);
        chk("R12 done one cycle", {31'd0, rsp_done}, 32'd0);
        req(1'b0, 2'd0, 3'd3, 32'h0);
        chk("R13 CR3 zero", rsp_rdata, 32'h0);
        req(1'b0, 2'd1, 3'd5, 32'h0);
        chk("R13 DR5 zero", rsp_rdata, 32'h0);
        // R5 16-bit bus forces bit 4 on write
        req(1'b1, 2'd0, 3'd0, 32'h0);
        req(1'b0, 2'd0, 3'd0, 32'h0);
        chk("R5 bit4 forced", rsp_rdata, 32'h0000_0010);
        cfg_bus16 = 1'b0;
        req(1'b1, 2'd0, 3'd0, 32'h0);
        req(1'b0, 2'd0, 3'd0, 32'h0);
        chk("R3 no force when not 486", rsp_rdata, 32'h0);
        cfg_is486 = 1'b1;
        req(1'b0, 2'd0, 3'd0, 32'h0);
        chk("R3 read-back forced", rsp_rdata, 32'h0000_0010);

        // Vector table: R2 R4 R7 R8 R9 R10 R11 R14
        for (int i = 0; i < NV; i++) begin
            req(VEC[i].wr, VEC[i].cls, VEC[i].idx, VEC[i].wdata);
            chk($sformatf("R14/R10 vec%0d rdata", i), rsp_rdata, VEC[i].rdata);
            chk($sformatf("R2 vec%0d ud", i), {31'd0, fault_ud}, {31'd0, VEC[i].ud});
            chk($sformatf("R4/R8/R9 vec%0d flush", i), {31'd0, tlb_flush}, {31'd0, VEC[i].flush});
            chk($sformatf("R7 vec%0d wait", i), {31'd0, wait_update}, {31'd0, VEC[i].waitu});
            chk($sformatf("R11 vec%0d cycles", i), {28'd0, rsp_cycles}, {28'd0, VEC[i].cyc});
        end
        chk("R6 pmode set", {31'd0, pmode}, 32'd1);
        chk("R7 cache off with bit30", {31'd0, cache_int_en}, 32'd0);

        // R1 privilege faults
        priv_level = 2'd3;
        req(1'b1, 2'd0, 3'd3, 32'h0000_AAAA);
        chk("R1 gp on cpl3", {31'd0, fault_gp}, 32'd1);
        chk("R1 no flush", {31'd0, tlb_flush}, 32'd0);
        chk("R11 cycles 0 on gp", {28'd0, rsp_cycles}, 32'd0);
        chk("R2 no ud with gp", {31'd0, fault_ud}, 32'd0);
        priv_level = 2'd0; vm_flag = 1'b1;
        req(1'b0, 2'd1, 3'd3, 32'h0);
        chk("R1 gp on vm", {31'd0, fault_gp}, 32'd1);
        chk("R1 rdata 0 on gp", rsp_rdata, 32'h0);
        vm_flag = 1'b0;
        req(1'b0, 2'd0, 3'd3, 32'h0);
        chk("R1 CR3 unchanged", rsp_rdata, 32'h0000_1000);

        // R4 R6 R7 clearing CR0
        req(1'b1, 2'd0, 3'd0, 32'h0);
        chk("R4 flush on pe/pg change", {31'd0, tlb_flush}, 32'd1);
        chk("R7 wait on bit30 change", {31'd0, wait_update}, 32'd1);
        chk("R6 pmode cleared", {31'd0, pmode}, 32'd0);
        chk("R7 cache on", {31'd0, cache_int_en}, 32'd1);
        @(negedge clk);
        chk("R12 flush gone", {31'd0, tlb_flush}, 32'd0);
        priv_level = 2'd3;
        req(1'b0, 2'd0, 3'd3, 32'h0);
        chk("R1 no gp when pe clear", {31'd0, fault_gp}, 32'd0);
        chk("R1 read ok when pe clear", rsp_rdata, 32'h0000_1000);
        priv_level = 2'd0;

        // R2 CR4 absent
        cfg_has_cr4 = 1'b0;
        req(1'b0, 2'd0, 3'd4, 32'h0);
        chk("R2 ud on absent CR4", {31'd0, fault_ud}, 32'd1);

        // R7 no cache present
        cfg_has_cache = 1'b0;
        @(negedge clk);
        chk("R7 cache_int_en without cache", {31'd0, cache_int_en}, 32'd0);
        req(1'b1, 2'd0, 3'd0, 32'h4000_0000);
        chk("R7 no wait without cache", {31'd0, wait_update}, 32'd0);
        chk("R4 no flush when pe/pg same", {31'd0, tlb_flush}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule